// File: doc/BRIEF.md
# Multi-channel shadowed PWM controller

This block generates four independent pulse-width-modulated outputs. Software reaches every channel through one small register window, one 32-byte slice per channel. In each slice it sets a prescale divider, a period length and an active length, and it switches the channel on or off. Each running channel counts prescaled ticks through a period and drives its output high for the first part of that period and low for the rest.

The period length and the divider are held in shadow registers. Writing the active length commits the three values together. A committed set waits in a pending slot and is loaded only when the running period wraps, so no period ever mixes old and new settings. Clearing the enable bit does not wait for the period to end: the output drops at once and the counters return to zero. A later enable starts a new period from the values already committed.

Each channel is a two-state machine. `CH_IDLE` holds the counters at zero and keeps the output low. `CH_ACTIVE` runs the counters. The transition *start* (`CH_IDLE` to `CH_ACTIVE`) happens on the first clock with enable set and also loads any pending set. The transition *stop* (`CH_ACTIVE` to `CH_IDLE`) happens on the first clock with enable clear. Inside `CH_ACTIVE`, the self-loop *wrap* fires on the last prescaled tick of a period and loads any pending set.

Top module: `pwm_multi_ctrl`

## Requirements
- R1: Channel c occupies bus addresses c*32 to c*32+31. Offset 0x00 holds the prescale value (8 bits), 0x04 the period length (8 bits), 0x08 the active length (16 bits) and 0x18 the enable flag (bit 0). A read returns the last value written, masked to its field, with all other bits zero. It completes combinationally in the same cycle. Unmapped offsets and addresses beyond the last channel read as zero.
- R2: After reset every register reads zero and every output is low.
- R3: With committed prescale P, period length M and active length D, a running channel repeats a period of (P+1)*M cycles. The output is high for the first (P+1)*min(D,M) cycles of each period. If D is 0 or M is 0, the output stays low.
- R4: Writes to the prescale and period-length registers only change shadow copies. They do not alter the waveform of a running channel until a write to the active-length register commits them. The shadows read back as written, even when not committed.
- R5: A committed set takes effect at the first period boundary on or after the commit clock. This includes a commit in the last cycle of a period. The period that is running finishes with its old settings.
- R6: In the cycle after a write that clears enable, the output is low, and it stays low while enable is clear.
- R7: In the cycle after a write that sets enable, the output is still low. The first period starts one cycle later from counter zero, with the committed values. A disable followed by a re-enable starts a fresh period.
- R8: Channels are independent. Activity on one channel leaves the outputs of disabled channels low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register samples on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| pwm_out | output | 4 | One active-high PWM output per channel |

## Verification
The assertions assume one bus access per cycle, with known address and data while `bus_sel` is high, and the bus held idle (`bus_sel` low) between accesses. The stimulus drives every access for exactly one clock at the falling edge and then returns the bus to idle. It uses only word-aligned offsets, apart from deliberate probes of unmapped locations. The sweep covers prescale 0 to 2, period lengths 0, 1, 2, 3 and 5, and every active length from 0 to one past the period length. Separate sequences commit inside a period, in its last cycle and in the first cycle of the next one, and disable a channel while its output is high.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;

    localparam int PRE_W  = 8;
    localparam int MOD_W  = 8;
    localparam int DUTY_W = 16;

    typedef enum logic [0:0] {
        CH_IDLE   = 1'b0,
        CH_ACTIVE = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MOD_W-1:0]  modv;
        logic [DUTY_W-1:0] duty;
    } pwm_cfg_t;

endpackage

// File: rtl/pwm_ctl_regs.sv
module pwm_ctl_regs
    import pwm_ctl_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int STRIDE_LOG2 = 5,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [NUM_CH-1:0]       en_o,
    output logic [NUM_CH-1:0]       commit_o,
    output pwm_cfg_t [NUM_CH-1:0]   cfg_o
);

    localparam int CH_W = $clog2(NUM_CH);
    localparam logic [STRIDE_LOG2-1:0] OFS_PRE  = STRIDE_LOG2'(8'h00);
    localparam logic [STRIDE_LOG2-1:0] OFS_MOD  = STRIDE_LOG2'(8'h04);
    localparam logic [STRIDE_LOG2-1:0] OFS_DUTY = STRIDE_LOG2'(8'h08);
    localparam logic [STRIDE_LOG2-1:0] OFS_EN   = STRIDE_LOG2'(8'h18);

    logic [CH_W-1:0]        ch_idx;
    logic [STRIDE_LOG2-1:0] ofs;
    logic                   acc_hit;
    logic                   wr_go;

    logic [PRE_W-1:0]  pre_all  [NUM_CH];
    logic [MOD_W-1:0]  mod_all  [NUM_CH];
    logic [DUTY_W-1:0] duty_all [NUM_CH];
    logic              en_all   [NUM_CH];

    assign ofs     = bus_addr[STRIDE_LOG2-1:0];
    assign ch_idx  = bus_addr[STRIDE_LOG2 +: CH_W];
    assign acc_hit = ((bus_addr >> (STRIDE_LOG2 + CH_W)) == '0)
                     && ({1'b0, ch_idx} < (CH_W+1)'(NUM_CH));
    assign wr_go   = bus_sel && bus_wr && acc_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic              hit;
        logic [PRE_W-1:0]  pre_q;
        logic [MOD_W-1:0]  mod_q;
        logic [DUTY_W-1:0] duty_q;
        logic              en_q;

        assign hit = wr_go && (ch_idx == CH_W'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pre_q  <= '0;
                mod_q  <= '0;
                duty_q <= '0;
                en_q   <= 1'b0;
            end else if (hit) begin
                case (ofs)
                    OFS_PRE:  pre_q  <= bus_wdata[PRE_W-1:0];
                    OFS_MOD:  mod_q  <= bus_wdata[MOD_W-1:0];
                    OFS_DUTY: duty_q <= bus_wdata[DUTY_W-1:0];
                    OFS_EN:   en_q   <= bus_wdata[0];
                    default: ;
                endcase
            end
        end

        assign pre_all[c]  = pre_q;
        assign mod_all[c]  = mod_q;
        assign duty_all[c] = duty_q;
        assign en_all[c]   = en_q;

        assign en_o[c]     = en_q;
        assign commit_o[c] = hit && (ofs == OFS_DUTY);
        assign cfg_o[c]    = '{pre: pre_q, modv: mod_q, duty: bus_wdata[DUTY_W-1:0]};
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && acc_hit) begin
            case (ofs)
                OFS_PRE:  bus_rdata = DATA_W'(pre_all[ch_idx]);
                OFS_MOD:  bus_rdata = DATA_W'(mod_all[ch_idx]);
                OFS_DUTY: bus_rdata = DATA_W'(duty_all[ch_idx]);
                OFS_EN:   bus_rdata = DATA_W'(en_all[ch_idx]);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R4: at most one channel commits per access
    p_commit_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_o));

    // R1: bits above the widest field always read zero
    p_read_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |-> (bus_rdata[DATA_W-1:DUTY_W] == '0));

endmodule

// File: rtl/pwm_ctl_chan.sv
module pwm_ctl_chan
    import pwm_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_i,
    input  logic     commit_i,
    input  pwm_cfg_t cfg_i,
    output logic     pwm_o
);

    ch_state_e         state_q, state_d;
    logic [PRE_W-1:0]  pre_cnt_q;
    logic [MOD_W-1:0]  per_cnt_q;
    pwm_cfg_t          act_q, pend_q, nxt_cfg;
    logic              pend_v_q, nxt_v;
    logic              tick, wrap, load;

    assign nxt_cfg = commit_i ? cfg_i : pend_q;
    assign nxt_v   = commit_i || pend_v_q;
    assign tick    = (pre_cnt_q == act_q.pre);
    assign wrap    = tick && (({1'b0, per_cnt_q} + 1'b1) >= {1'b0, act_q.modv});

    // next-state logic: start, stop, wrap
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (en_i) begin
                    state_d = CH_ACTIVE;
                    load    = 1'b1;
                end
            end
            CH_ACTIVE: begin
                if (!en_i) begin
                    state_d = CH_IDLE;
                end else if (wrap) begin
                    load = 1'b1;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // counters and configuration slots
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt_q <= '0;
            per_cnt_q <= '0;
            act_q     <= '0;
            pend_q    <= '0;
            pend_v_q  <= 1'b0;
        end else begin
            if (state_q != CH_ACTIVE || !en_i) begin
                pre_cnt_q <= '0;
                per_cnt_q <= '0;
            end else if (tick) begin
                pre_cnt_q <= '0;
                per_cnt_q <= wrap ? '0 : per_cnt_q + 1'b1;
            end else begin
                pre_cnt_q <= pre_cnt_q + 1'b1;
            end

            if (load && nxt_v) begin
                act_q    <= nxt_cfg;
                pend_v_q <= 1'b0;
            end else if (commit_i) begin
                pend_q   <= cfg_i;
                pend_v_q <= 1'b1;
            end
        end
    end

    // output logic
    always_comb begin
        pwm_o = en_i && (state_q == CH_ACTIVE) && (act_q.modv != '0)
                && (DUTY_W'(per_cnt_q) < act_q.duty);
    end

    // R3: period counter stays inside the committed period length
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACTIVE && act_q.modv != '0) |-> (per_cnt_q < act_q.modv));

    // R3: prescale counter never passes its limit
    p_pre_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACTIVE) |-> (pre_cnt_q <= act_q.pre));

    // R5: active settings change only at a period boundary
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACTIVE && en_i && !wrap) |=> $stable(act_q));

    // R6: clearing enable returns the channel to idle with zeroed counters
    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACTIVE && !en_i) |=> (state_q == CH_IDLE && per_cnt_q == '0));

    // R7: a start begins from counter zero
    p_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && en_i) |=> (pre_cnt_q == '0 && per_cnt_q == '0));

endmodule

// File: rtl/pwm_multi_ctrl.sv
module pwm_multi_ctrl
    import pwm_ctl_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int STRIDE_LOG2 = 5,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]     ch_en;
    logic [NUM_CH-1:0]     ch_commit;
    pwm_cfg_t [NUM_CH-1:0] ch_cfg;

    pwm_ctl_regs #(
        .NUM_CH      (NUM_CH),
        .STRIDE_LOG2 (STRIDE_LOG2),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_o      (ch_en),
        .commit_o  (ch_commit),
        .cfg_o     (ch_cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pwm_ctl_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (ch_en[c]),
            .commit_i (ch_commit[c]),
            .cfg_i    (ch_cfg[c]),
            .pwm_o    (pwm_out[c])
        );
    end

    // R8: a disabled channel never drives its output
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ch_en == '0) && (ch_en == '0) |-> (pwm_out == '0));

endmodule

// File: tb/test_pwm_multi_ctrl.sv
module test_pwm_multi_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwm_multi_ctrl i_pwm_multi_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    localparam logic [4:0] O_PRE = 5'h00, O_MOD = 5'h04, O_DUTY = 5'h08, O_EN = 5'h18;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_wr(input int ch, input logic [4:0] ofs, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(ch * 32) | {3'b0, ofs}; bus_wdata = d;
    endtask

    task automatic drive_idle();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_write(input int ch, input logic [4:0] ofs, input logic [31:0] d);
        @(negedge clk); drive_wr(ch, ofs, d);
        @(negedge clk); drive_idle();
    endtask

    task automatic bus_read_raw(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        drive_idle();
    endtask

    function automatic logic exp_out(input int pre, input int md, input int dt, input int t);
        if (md == 0 || dt == 0) return 1'b0;
        return ((t / (pre + 1)) % md) < dt;
    endfunction

    // enable channel ch and check the idle cycle after the write (R7)
    task automatic start_ch(input int ch);
        @(negedge clk); drive_wr(ch, O_EN, 32'h1);
        @(negedge clk); drive_idle();
        chk("R7 start-delay", {31'b0, pwm_out[ch]}, 32'h0);
    endtask

    task automatic run_pattern(input int ch, input int pre, input int md, input int dt);
        int n;
        bus_write(ch, O_PRE, pre);
        bus_write(ch, O_MOD, md);
        bus_write(ch, O_DUTY, dt);
        start_ch(ch);
        n = 2 * (pre + 1) * ((md == 0) ? 1 : md) + 2;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            chk("R3 waveform", {31'b0, pwm_out[ch]}, {31'b0, exp_out(pre, md, dt, t)});
            for (int o = 0; o < 4; o++)
                if (o != ch) chk("R8 others-low", {31'b0, pwm_out[o]}, 32'h0);
        end
        bus_write(ch, O_EN, 32'h0);
        chk("R6 stop", {31'b0, pwm_out[ch]}, 32'h0);
    endtask

    // commit at sample tw while running 2/4/1; new set 1/6/3 (pre 0)
    task automatic mid_commit(input int tw);
        int bnd;
        logic e;
        bnd = 8 * (tw / 8 + 1);
        bus_write(1, O_PRE, 1);
        bus_write(1, O_MOD, 4);
        bus_write(1, O_DUTY, 1);
        start_ch(1);
        for (int t = 0; t < bnd + 14; t++) begin
            @(negedge clk);
            if (t < bnd) e = exp_out(1, 4, 1, t);
            else         e = exp_out(0, 6, 3, t - bnd);
            if (t < bnd) chk("R4 shadow-no-effect/R5 old-period", {31'b0, pwm_out[1]}, {31'b0, e});
            else         chk("R5 new-after-boundary", {31'b0, pwm_out[1]}, {31'b0, e});
            if (t == 1)       drive_wr(1, O_PRE, 0);
            else if (t == 2)  drive_wr(1, O_MOD, 6);
            else if (t == tw) drive_wr(1, O_DUTY, 3);
            else              drive_idle();
        end
        bus_write(1, O_EN, 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++; n_bad++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        chk("R2 outputs-low", {28'b0, pwm_out}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            bus_read_raw(8'(c * 32) | 8'h00, rd); chk("R2 pre-zero", rd, 0);
            bus_read_raw(8'(c * 32) | 8'h04, rd); chk("R2 mod-zero", rd, 0);
            bus_read_raw(8'(c * 32) | 8'h08, rd); chk("R2 duty-zero", rd, 0);
            bus_read_raw(8'(c * 32) | 8'h18, rd); chk("R2 en-zero", rd, 0);
        end

        // R1 / R4: readback masking and shadow visibility
        bus_write(3, O_MOD, 32'h0000_0007);
        bus_read_raw(8'h64, rd); chk("R4 shadow-readback", rd, 32'h7);
        bus_write(3, O_PRE, 32'hFFFF_FABC);
        bus_write(3, O_MOD, 32'h0000_01FF);
        bus_write(3, O_DUTY, 32'hA001_2345);
        bus_write(3, O_EN, 32'h0000_0002);
        bus_read_raw(8'h60, rd); chk("R1 pre-mask", rd, 32'hBC);
        bus_read_raw(8'h64, rd); chk("R1 mod-mask", rd, 32'hFF);
        bus_read_raw(8'h68, rd); chk("R1 duty-mask", rd, 32'h2345);
        bus_read_raw(8'h78, rd); chk("R1 en-bit0", rd, 32'h0);
        bus_read_raw(8'h6C, rd); chk("R1 unmapped-ofs", rd, 32'h0);
        bus_read_raw(8'h80, rd); chk("R1 beyond-window", rd, 32'h0);
        chk("R8 ch3-stays-off", {31'b0, pwm_out[3]}, 32'h0);

        // R3 / R7 / R8: sweep of small configurations
        begin
            int k = 0;
            int mods[5] = '{0, 1, 2, 3, 5};
            for (int p = 0; p < 3; p++)
                for (int mi = 0; mi < 5; mi++)
                    for (int d = 0; d <= mods[mi] + 1; d++) begin
                        run_pattern(k % 4, p, mods[mi], d);
                        k++;
                    end
        end

        // R5: commit inside, at end of, and just after the first period
        mid_commit(3);
        mid_commit(7);
        mid_commit(8);

        // R6 / R7: immediate stop while high, then fresh restart
        bus_write(2, O_PRE, 2);
        bus_write(2, O_MOD, 5);
        bus_write(2, O_DUTY, 2);
        start_ch(2);
        for (int t = 0; t < 5; t++) begin
            @(negedge clk);
            chk("R3 pre-stop", {31'b0, pwm_out[2]}, {31'b0, exp_out(2, 5, 2, t)});
            if (t == 4) drive_wr(2, O_EN, 0); else drive_idle();
        end
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            drive_idle();
            chk("R6 immediate-low", {31'b0, pwm_out[2]}, 32'h0);
        end
        start_ch(2);
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            chk("R7 fresh-restart", {31'b0, pwm_out[2]}, {31'b0, exp_out(2, 5, 2, t)});
        end
        bus_write(2, O_EN, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule